// File: doc/BRIEF.md
# Batch Operand Adder with Pulsed Completion Interrupt

This peripheral hangs on a simple memory-mapped processor bus (address, write strobe, read strobe, write data, read data). Software loads a batch of operand pairs into internal storage, then writes a command word. The block works through the stored pairs one per clock and stores every sum in a result register that software can read back. When the last sum is stored, the block raises a completion interrupt. The interrupt is a pulse of fixed length that clears itself, so software never has to acknowledge it.

Two things can enable the interrupt: an external switch input, or a control register that holds the value 1. Writing any other value to that register, for example 2, turns the register-side enable off. One status LED toggles on every bus access to a fixed data-arrival offset. A second LED carries the interrupt pulse so that it can be seen on the board.

The address space has two regions, chosen by the top address bit. The control region (bit 8 = 0) holds the control register at byte offset 0x00 and the status word at 0x04. The data region (bit 8 = 1) holds the operands, the command offset and the results. Operand pair i sits at data offsets 8*i (first operand) and 8*i+4 (second operand). The command offset is 8*N_PAIRS (0x50 by default). Result i is at 0x80 + 4*i.

Top module: `batch_adder`

## Requirements
- R1: A write to data offset 8*i stores the low OP_W bits as operand A of pair i, and a write to 8*i+4 stores operand B. A read of either offset returns the stored value, zero-extended, on the bus during the cycle after the read strobe.
- R2: Operand writes alone start no computation. The status busy bit stays 0 and no interrupt pulse occurs.
- R3: A write to the command offset starts the batch. Result i at data offset 0x80+4*i holds the full OP_W+1-bit sum A_i+B_i, zero-extended. Busy falls and done rises 11 clock edges after the edge that captured the command.
- R4: After a batch, the interrupt output rises on the 12th clock edge after the command edge. It stays high for exactly PULSE_W cycles (16 by default) and then returns to 0 by itself.
- R5: The interrupt is enabled when the switch input is 1 or when the control register (control offset 0x00, reset value 0, readable) holds 1.
- R6: With the switch input at 0 and the control register set to 2, a finished batch raises no pulse, but the results are still computed and done still becomes 1.
- R7: Every read or write at data offset 0x04 toggles the data LED (reset value 0). Accesses to other offsets leave it unchanged.
- R8: The interrupt LED output equals the interrupt output in every cycle.
- R9: A command written while a pulse is high drops the pulse at that edge and restarts the batch. The new batch then produces exactly one fresh pulse.
- R10: The top address bit selects the region: 0 for control, 1 for data. Control accesses do not touch data storage, and reads of unmapped word offsets return 0.
- R11: The status word (control offset 0x04) carries busy in bit 0 and done in bit 1. Result registers keep their values when operands change and are rewritten only by the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; top bit selects the region |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid during the cycle after the read strobe |
| sw_irq_en | input | 1 | Switch input that enables the interrupt |
| irq_o | output | 1 | Self-clearing completion interrupt pulse |
| led_data_o | output | 1 | LED that toggles on data-arrival accesses |
| led_irq_o | output | 1 | LED copy of the interrupt pulse |

## Verification
Read data is due during the cycle after the read strobe. The bench queues each expected word when it issues the strobe and compares it on the falling edge that follows the capturing edge. Counted from the edge that captures the command, busy clears on edge 11 and the interrupt rises on edge 12. The bench checks the interrupt low after 11 falling edges and high after the 12th, then counts exactly 16 high samples. The data LED is checked on the falling edge right after each access. Absent pulses are checked with a rising-edge counter that the bench reads 40 cycles after the command.

// File: rtl/batch_add_pkg.sv
package batch_add_pkg;
  typedef enum logic [2:0] {
    RS_NONE,
    RS_CTRL,
    RS_STAT,
    RS_OPA,
    RS_OPB,
    RS_RES
  } rsrc_e;
endpackage

// File: rtl/badd_decode.sv
module badd_decode
  import batch_add_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int N_PAIRS = 10,
  parameter int IDX_W   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              ctrl_wr,
  output logic              cmd_wr,
  output logic              opa_wr,
  output logic              opb_wr,
  output logic [IDX_W-1:0]  pair_idx,
  output logic [IDX_W-1:0]  res_idx,
  output logic              led_hit,
  output rsrc_e             rsrc
);
  localparam int OFF_W    = ADDR_W - 3;
  localparam int CMD_WORD = 2 * N_PAIRS;
  localparam int RES_BASE = 1 << (OFF_W - 1);

  logic             aligned;
  logic             dat_sel;
  logic             ctl_sel;
  logic [OFF_W-1:0] word;
  logic             op_hit;
  logic             res_hit;

  assign aligned = (addr[1:0] == 2'b00);
  assign dat_sel = aligned && addr[ADDR_W-1];
  assign ctl_sel = aligned && !addr[ADDR_W-1];
  assign word    = addr[ADDR_W-2:2];

  always_comb begin
    op_hit   = dat_sel && (int'(word) < CMD_WORD);
    res_hit  = dat_sel && (int'(word) >= RES_BASE) && (int'(word) < RES_BASE + N_PAIRS);
    pair_idx = IDX_W'(word >> 1);
    res_idx  = IDX_W'(int'(word) - RES_BASE);
    ctrl_wr  = wr && ctl_sel && (word == '0);
    cmd_wr   = wr && dat_sel && (int'(word) == CMD_WORD);
    opa_wr   = wr && op_hit && !word[0];
    opb_wr   = wr && op_hit && word[0];
    led_hit  = (wr || rd) && dat_sel && (int'(word) == 1);
    rsrc     = RS_NONE;
    if (ctl_sel && int'(word) == 0)      rsrc = RS_CTRL;
    else if (ctl_sel && int'(word) == 1) rsrc = RS_STAT;
    else if (op_hit)                     rsrc = word[0] ? RS_OPB : RS_OPA;
    else if (res_hit)                    rsrc = RS_RES;
  end
endmodule

// File: rtl/badd_opstore.sv
module badd_opstore #(
  parameter int N_PAIRS = 10,
  parameter int OP_W    = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             wa_en,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] widx,
  input  logic [OP_W-1:0]  wdata,
  input  logic             bus_re,
  input  logic [IDX_W-1:0] bus_idx,
  output logic [OP_W-1:0]  bus_a,
  output logic [OP_W-1:0]  bus_b,
  input  logic             eng_re,
  input  logic [IDX_W-1:0] eng_idx,
  output logic [OP_W-1:0]  eng_a,
  output logic [OP_W-1:0]  eng_b
);
  logic [OP_W-1:0] a_mem [N_PAIRS];
  logic [OP_W-1:0] b_mem [N_PAIRS];

  always_ff @(posedge clk) begin
    if (wa_en) a_mem[widx] <= wdata;
    if (wb_en) b_mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (bus_re) begin
      bus_a <= a_mem[bus_idx];
      bus_b <= b_mem[bus_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (eng_re) begin
      eng_a <= a_mem[eng_idx];
      eng_b <= b_mem[eng_idx];
    end
  end
endmodule

// File: rtl/badd_engine.sv
module badd_engine #(
  parameter int N_PAIRS = 10,
  parameter int OP_W    = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  output logic             res_we,
  output logic [IDX_W-1:0] res_idx,
  output logic [OP_W:0]    res_sum,
  output logic             fin,
  output logic             busy,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_PAIRS - 1);

  logic             act_q;
  logic             val_q;
  logic [IDX_W-1:0] ridx_q;
  logic [IDX_W-1:0] widx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      val_q  <= 1'b0;
      ridx_q <= '0;
      widx_q <= '0;
      fin    <= 1'b0;
      done   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        act_q  <= 1'b1;
        val_q  <= 1'b0;
        ridx_q <= '0;
        done   <= 1'b0;
      end else begin
        val_q  <= act_q;
        widx_q <= ridx_q;
        if (act_q) begin
          if (ridx_q == LAST) act_q  <= 1'b0;
          else                ridx_q <= ridx_q + 1'b1;
        end
        if (val_q && widx_q == LAST) begin
          fin  <= 1'b1;
          done <= 1'b1;
        end
      end
    end
  end

  assign rd_en   = act_q;
  assign rd_idx  = ridx_q;
  assign res_we  = val_q;
  assign res_idx = widx_q;
  assign res_sum = {1'b0, op_a} + {1'b0, op_b};
  assign busy    = act_q | val_q;
endmodule

// File: rtl/badd_resstore.sv
module badd_resstore #(
  parameter int N_PAIRS = 10,
  parameter int SUM_W   = 17,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [SUM_W-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] ridx,
  output logic [SUM_W-1:0] rdata
);
  logic [SUM_W-1:0] mem [N_PAIRS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    if (re) rdata <= mem[ridx];
  end
endmodule

// File: rtl/badd_irq.sv
module badd_irq #(
  parameter int PULSE_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fin,
  input  logic clear,
  input  logic enable,
  output logic irq,
  output logic led
);
  localparam int CNT_W = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq   <= 1'b0;
      led   <= 1'b0;
      cnt_q <= '0;
    end else if (clear) begin
      irq   <= 1'b0;
      led   <= 1'b0;
      cnt_q <= '0;
    end else if (fin && enable) begin
      irq   <= 1'b1;
      led   <= 1'b1;
      cnt_q <= CNT_W'(PULSE_W - 1);
    end else if (irq) begin
      if (cnt_q == '0) begin
        irq <= 1'b0;
        led <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/batch_adder.sv
module batch_adder
  import batch_add_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 32,
  parameter int OP_W    = 16,
  parameter int N_PAIRS = 10,
  parameter int PULSE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sw_irq_en,
  output logic              irq_o,
  output logic              led_data_o,
  output logic              led_irq_o
);
  localparam int IDX_W = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1;
  localparam int SUM_W = OP_W + 1;
  localparam int PAD_W = DATA_W - SUM_W;

  logic             ctrl_wr, cmd_wr, opa_wr, opb_wr, led_hit;
  logic [IDX_W-1:0] pair_idx, res_ridx;
  rsrc_e            rsrc, rsrc_q;

  logic             eng_re;
  logic [IDX_W-1:0] eng_idx, res_widx;
  logic [OP_W-1:0]  bus_a, bus_b, eng_a, eng_b;
  logic             res_we, fin, busy, done;
  logic [SUM_W-1:0] res_sum, res_rdata;

  logic [DATA_W-1:0] ctrl_q, reg_rd_q;
  logic              led_data_q;
  logic              irq_en;

  badd_decode #(.ADDR_W(ADDR_W), .N_PAIRS(N_PAIRS), .IDX_W(IDX_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .ctrl_wr(ctrl_wr), .cmd_wr(cmd_wr), .opa_wr(opa_wr), .opb_wr(opb_wr),
    .pair_idx(pair_idx), .res_idx(res_ridx), .led_hit(led_hit), .rsrc(rsrc)
  );

  badd_opstore #(.N_PAIRS(N_PAIRS), .OP_W(OP_W), .IDX_W(IDX_W)) u_ops (
    .clk(clk), .wa_en(opa_wr), .wb_en(opb_wr), .widx(pair_idx),
    .wdata(bus_wdata[OP_W-1:0]),
    .bus_re(bus_rd && (rsrc == RS_OPA || rsrc == RS_OPB)), .bus_idx(pair_idx),
    .bus_a(bus_a), .bus_b(bus_b),
    .eng_re(eng_re), .eng_idx(eng_idx), .eng_a(eng_a), .eng_b(eng_b)
  );

  badd_engine #(.N_PAIRS(N_PAIRS), .OP_W(OP_W), .IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst(rst), .start(cmd_wr),
    .rd_en(eng_re), .rd_idx(eng_idx), .op_a(eng_a), .op_b(eng_b),
    .res_we(res_we), .res_idx(res_widx), .res_sum(res_sum),
    .fin(fin), .busy(busy), .done(done)
  );

  badd_resstore #(.N_PAIRS(N_PAIRS), .SUM_W(SUM_W), .IDX_W(IDX_W)) u_res (
    .clk(clk), .we(res_we), .widx(res_widx), .wdata(res_sum),
    .re(bus_rd && rsrc == RS_RES), .ridx(res_ridx), .rdata(res_rdata)
  );

  assign irq_en = sw_irq_en || (ctrl_q == DATA_W'(1));

  badd_irq #(.PULSE_W(PULSE_W)) u_irq (
    .clk(clk), .rst(rst), .fin(fin), .clear(cmd_wr), .enable(irq_en),
    .irq(irq_o), .led(led_irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      led_data_q <= 1'b0;
      rsrc_q     <= RS_NONE;
      reg_rd_q   <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata;
      if (led_hit) led_data_q <= ~led_data_q;
      rsrc_q <= bus_rd ? rsrc : RS_NONE;
      if (bus_rd) reg_rd_q <= (rsrc == RS_STAT) ? DATA_W'({done, busy}) : ctrl_q;
    end
  end

  always_comb begin
    unique case (rsrc_q)
      RS_CTRL, RS_STAT: bus_rdata = reg_rd_q;
      RS_OPA:           bus_rdata = DATA_W'(bus_a);
      RS_OPB:           bus_rdata = DATA_W'(bus_b);
      RS_RES:           bus_rdata = {{PAD_W{1'b0}}, res_rdata};
      default:          bus_rdata = '0;
    endcase
  end

  assign led_data_o = led_data_q;
endmodule

// File: rtl/batch_adder_chk.sv
module batch_adder_chk #(
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 32,
  parameter int PULSE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              sw_irq_en,
  input logic              irq_o,
  input logic              led_irq_o,
  input logic              led_data_o,
  input logic              fin,
  input logic              busy,
  input logic              cmd_wr,
  input logic [DATA_W-1:0] ctrl_q
);
  logic [31:0] run_q;
  logic        led_acc;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= irq_o ? run_q + 1 : '0;
  end

  assign led_acc = (bus_wr || bus_rd) && bus_addr[ADDR_W-1] &&
                   (bus_addr[ADDR_W-2:0] == (ADDR_W-1)'(4));

  p_no_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_wr));

  p_fin_idle_r3: assert property (@(posedge clk) disable iff (rst)
    fin |-> !busy);

  p_rise_after_fin_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(fin));

  p_width_r4: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (run_q < PULSE_W));

  p_rise_enabled_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(sw_irq_en || ctrl_q == DATA_W'(1)));

  p_led_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    led_acc |=> (led_data_o != $past(led_data_o)));

  p_led_mirror_r8: assert property (@(posedge clk) disable iff (rst)
    led_irq_o == irq_o);

  p_cmd_clears_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> !irq_o);
endmodule

bind batch_adder batch_adder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_W(PULSE_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .sw_irq_en(sw_irq_en), .irq_o(irq_o), .led_irq_o(led_irq_o),
  .led_data_o(led_data_o), .fin(fin), .busy(busy), .cmd_wr(cmd_wr),
  .ctrl_q(ctrl_q)
);

// File: tb/batch_adder_tb_top.sv
module batch_adder_tb_top;
  localparam int NP = 10;
  localparam int PW = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic [8:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        sw_irq_en;
  logic        irq_o, led_data_o, led_irq_o;

  always #10 clk = ~clk;

  batch_adder dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_irq_en(sw_irq_en),
    .irq_o(irq_o), .led_data_o(led_data_o), .led_irq_o(led_irq_o)
  );

  int checks = 0;
  int errors = 0;
  int rises  = 0;
  logic irq_prev = 1'b0;
  logic rd_seen;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] a_v[NP];
  logic [15:0] b_v[NP];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic bus_write(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [8:0] a, logic [31:0] exp, string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // scoreboard monitor: read data due in the cycle after the strobe
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rst !== 1'b1 && rd_seen === 1'b1) begin
      if (exp_q.size() == 0) begin
        check("scoreboard", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
    if (irq_o === 1'b1 && irq_prev !== 1'b1) rises++;
    irq_prev = irq_o;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  function automatic logic [31:0] sum_of(int i);
    return 32'({1'b0, a_v[i]} + {1'b0, b_v[i]});
  endfunction

  initial begin
    int r0;
    int width;
    logic led0;
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; sw_irq_en = 1'b0;
    for (int i = 0; i < NP; i++) begin
      a_v[i] = 16'(i * 6000 + 123);
      b_v[i] = 16'(65535 - i * 17);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R4 reset irq", 32'(irq_o), 0);
    check("R7 reset led", 32'(led_data_o), 0);
    check("R8 reset led_irq", 32'(led_irq_o), 0);
    bus_read(9'h000, 0, "R5 ctrl reset value");

    // R1/R2: load operands
    for (int i = 0; i < NP; i++) begin
      bus_write(9'(9'h100 + 8 * i), 32'hABCD_0000 | 32'(a_v[i]));
      bus_write(9'(9'h104 + 8 * i), 32'(b_v[i]));
    end
    check("R7 toggled by write at 0x4", 32'(led_data_o), 1);
    bus_read(9'h118, 32'(a_v[3]), "R1 readback A3");
    bus_read(9'h13C, 32'(b_v[7]), "R1 readback B7");
    repeat (20) @(negedge clk);
    bus_read(9'h004, 0, "R2 status idle after operand writes");
    @(posedge clk);
    check("R2 no pulse without command", 32'(rises), 0);

    // R7 read access at 0x4 toggles, control status read does not
    bus_read(9'h104, 32'(b_v[0]), "R1 readback B0");
    check("R7 toggled by read at 0x4", 32'(led_data_o), 0);
    bus_read(9'h004, 0, "R10 status read");
    check("R10 control access leaves led", 32'(led_data_o), 0);

    // R5 enable through control register, R3/R4 timing
    bus_write(9'h000, 1);
    bus_read(9'h000, 1, "R5 ctrl readback");
    bus_write(9'h150, 0);
    repeat (11) @(negedge clk);
    check("R4 irq low before edge 12", 32'(irq_o), 0);
    @(negedge clk);
    check("R4 irq high after edge 12", 32'(irq_o), 1);
    check("R8 led_irq mirrors", 32'(led_irq_o), 1);
    width = 1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (irq_o !== 1'b1) break;
      width++;
    end
    check("R4 pulse width", 32'(width), PW);
    check("R8 led_irq low after pulse", 32'(led_irq_o), 0);
    bus_read(9'h004, 2, "R11 status done");
    for (int i = 0; i < NP; i++) bus_read(9'(9'h180 + 4 * i), sum_of(i), "R3 result");
    bus_read(9'h1C0, 0, "R10 unmapped read");

    // R6 disabled by value 2
    bus_write(9'h000, 2);
    @(posedge clk); r0 = rises;
    bus_write(9'h150, 0);
    repeat (40) @(negedge clk);
    @(posedge clk);
    check("R6 no pulse when disabled", 32'(rises), 32'(r0));
    bus_read(9'h004, 2, "R6 batch still done");
    bus_read(9'h184, sum_of(1), "R6 result computed");

    // R5 switch enable, R9 restart during pulse
    sw_irq_en = 1'b1;
    bus_write(9'h150, 0);
    repeat (12) @(negedge clk);
    check("R5 pulse with switch on", 32'(irq_o), 1);
    repeat (3) @(negedge clk);
    @(posedge clk); r0 = rises;
    bus_write(9'h150, 0);
    check("R9 pulse dropped by command", 32'(irq_o), 0);
    repeat (40) @(negedge clk);
    @(posedge clk);
    check("R9 one fresh pulse", 32'(rises), 32'(r0 + 1));

    // R11 results hold until next command
    led0 = led_data_o;
    bus_write(9'h100, 5);
    bus_read(9'h180, sum_of(0), "R11 result held");
    bus_read(9'h100, 5, "R1 new A0");
    bus_write(9'h000, 7);
    bus_read(9'h100, 5, "R10 control write leaves data");
    check("R7 other offsets leave led", 32'(led_data_o), 32'(led0));
    a_v[0] = 16'd5;
    bus_write(9'h150, 0);
    repeat (15) @(negedge clk);
    bus_read(9'h180, sum_of(0), "R3 new result");
    bus_read(9'h1A4, sum_of(9), "R3 last result");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule